// File: doc/BRIEF.md
# 64-bit Global Tick Timer

This block is a free-running 64-bit up-counter paired with a 64-bit compare value. Whenever the counter reaches or passes the compare value while comparison is switched on, the block records a match in a sticky status bit and, if interrupts are allowed, raises a level interrupt and a one-cycle tick pulse. In auto-increment mode each match adds a programmable 32-bit step to the compare value, so ticks repeat at a fixed interval without software rewriting the compare registers.

Software reaches everything through a 32-bit register port with a write strobe, a byte address and registered read data. The counter is exposed as two 32-bit words that are read separately, so software obtains a consistent 64-bit value by reading the upper word, the lower word and the upper word again, retrying when the two upper reads differ. Counter words may only be written while the counter is stopped, and compare words only while comparison is off, so a half-written compare value can never cause a match.

Top module: `tick_timer64`

## Requirements
- R1: After synchronous reset the counter, compare value, step value, control word and status bit are all zero, and irq and tick are low.
- R2: While control bit 0 (run) is 1 the counter increases by one on every clock edge, carrying from the low word (offset 0x00) into the high word (offset 0x04); while run is 0 it holds its value.
- R3: Writes to the counter words (0x00, 0x04) replace that word only while run is 0; while run is 1 they are ignored.
- R4: Writes to the compare words (low 0x10, high 0x14) take effect only while control bit 1 (compare enable) is 0; while it is 1 they are ignored.
- R5: A match is the condition compare enable = 1 and counter >= compare value; exactly one match event occurs each time the condition becomes true, and the event sets status bit 0 (offset 0x0C) on the next edge.
- R6: With control bit 3 (auto-increment) set, each match event adds the step register (offset 0x18, zero-extended) to the compare value, giving one event per step interval.
- R7: Status bit 0 stays set until software writes 1 to bit 0 at 0x0C; writing 0 leaves it unchanged.
- R8: With control bit 2 (interrupt enable) set, tick is high for one cycle on the edge after each match event, and irq is high while the status bit is set; with interrupt enable clear both stay low.
- R9: The control word lives at 0x08 and reads back only bits 3:0, all higher bits reading zero; read data is registered and presents the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps once per edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte offset of the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Level interrupt: status set and interrupt enable set |
| tick | output | 1 | One-cycle pulse per match when interrupt enable is set |

## Verification
A register write takes effect at the edge on which it is strobed, and read data appears one edge after the address, so the bench samples every result at the falling edge that follows the edge which produced it. The counter first steps on the edge after run is written, so with the counter at 0 and a compare value of N the tick is due N+1 edges after the enabling write; the bench records the edge number of each write and pushes the due edges of every expected tick into a queue. A monitor compares each observed tick against the head of that queue, flags any tick that was not expected, and the bench confirms the queue is empty at the end; counter values after stop are predicted from the number of edges run was set.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_STEP   = 5'h18;

  localparam int BIT_RUN  = 0;
  localparam int BIT_CMP  = 1;
  localparam int BIT_IEN  = 2;
  localparam int BIT_AUTO = 3;

  typedef struct packed {
    logic auto_inc;
    logic irq_en;
    logic cmp_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic [CNT_W/DATA_W-1:0]  word_we,
  input  logic [DATA_W-1:0]        wdata,
  output logic [CNT_W-1:0]         count
);
  localparam int NWORDS = CNT_W / DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (run) begin
      count <= count + CNT_W'(1);
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (word_we[w]) count[w*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/tt_compare.sv
module tt_compare #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmp_en,
  input  logic                     auto_inc,
  input  logic [CNT_W/DATA_W-1:0]  word_we,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        step,
  input  logic [CNT_W-1:0]         count,
  output logic [CNT_W-1:0]         cmp_val,
  output logic                     match_evt
);
  localparam int NWORDS = CNT_W / DATA_W;

  logic reached;
  logic seen;

  assign reached   = cmp_en && (count >= cmp_val);
  assign match_evt = reached && !seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
    end else if (match_evt && auto_inc) begin
      seen <= 1'b0;
    end else begin
      seen <= (seen || match_evt) && reached;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '0;
    end else if (match_evt && auto_inc) begin
      cmp_val <= cmp_val + CNT_W'(step);
    end else if (!cmp_en) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (word_we[w]) cmp_val[w*DATA_W +: DATA_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/tt_irq.sv
module tt_irq (
  input  logic clk,
  input  logic rst,
  input  logic match_evt,
  input  logic clr,
  input  logic irq_en,
  output logic status,
  output logic irq,
  output logic tick
);
  logic status_n;

  assign status_n = match_evt || (status && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      irq    <= 1'b0;
      tick   <= 1'b0;
    end else begin
      status <= status_n;
      irq    <= status_n && irq_en;
      tick   <= match_evt && irq_en;
    end
  end
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64 #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = tt_pkg::DATA_W,
  parameter int ADDR_W = tt_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              tick
);
  import tt_pkg::*;

  localparam int NWORDS = CNT_W / DATA_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  step_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cmp_q;
  logic [NWORDS-1:0]  cnt_we;
  logic [NWORDS-1:0]  cmp_we;
  logic               evt;
  logic               status_q;
  logic               stat_clr;

  genvar g;
  generate
    for (g = 0; g < NWORDS; g++) begin : g_dec
      assign cnt_we[g] = reg_we && (reg_addr == ADDR_W'(OFS_CNT_LO + 4*g));
      assign cmp_we[g] = reg_we && (reg_addr == ADDR_W'(OFS_CMP_LO + 4*g));
    end
  endgenerate

  assign stat_clr = reg_we && (reg_addr == OFS_STAT) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      step_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFS_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_addr == OFS_STEP) step_q <= reg_wdata;
    end
  end

  tt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .word_we (cnt_we),
    .wdata   (reg_wdata),
    .count   (cnt_q)
  );

  tt_compare #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .cmp_en    (ctrl_q.cmp_en),
    .auto_inc  (ctrl_q.auto_inc),
    .word_we   (cmp_we),
    .wdata     (reg_wdata),
    .step      (step_q),
    .count     (cnt_q),
    .cmp_val   (cmp_q),
    .match_evt (evt)
  );

  tt_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .match_evt (evt),
    .clr       (stat_clr),
    .irq_en    (ctrl_q.irq_en),
    .status    (status_q),
    .irq       (irq),
    .tick      (tick)
  );

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (reg_addr == ADDR_W'(OFS_CNT_LO + 4*w)) rd_mux = cnt_q[w*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(OFS_CMP_LO + 4*w)) rd_mux = cmp_q[w*DATA_W +: DATA_W];
    end
    if (reg_addr == OFS_CTRL) rd_mux = DATA_W'(ctrl_q);
    if (reg_addr == OFS_STAT) rd_mux = DATA_W'(status_q);
    if (reg_addr == OFS_STEP) rd_mux = step_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic              tick,
  input logic              status,
  input logic              run,
  input logic              cmp_en,
  input logic              evt,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp
);
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt == $past(cnt) + CNT_W'(1)));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !reg_we) |=> $stable(cnt));

  a_r4_cmp_locked: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !evt) |=> $stable(cmp));

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (status && !(reg_we && reg_addr == 5'h0C && reg_wdata[0])) |=> status);

  a_r5_evt_sets: assert property (@(posedge clk) disable iff (rst)
    evt |=> status);

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> status);

  a_r8_tick_cause: assert property (@(posedge clk) disable iff (rst)
    tick |-> status);
endmodule

bind tick_timer64 tt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .tick      (tick),
  .status    (status_q),
  .run       (ctrl_q.run),
  .cmp_en    (ctrl_q.cmp_en),
  .evt       (evt),
  .cnt       (cnt_q),
  .cmp       (cmp_q)
);

// File: tb/tick_timer64_bench.sv
module tick_timer64_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        tick;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_edge = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer64 u_tick_timer64 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .tick(tick)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    last_edge = cyc;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor: every tick must match the next due edge
  always @(negedge clk) begin
    if (!rst && tick && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected tick actual=%0d expected=none", cyc);
      end else begin
        int due;
        due = exp_q.pop_front();
        if (due != cyc) begin
          failures++;
          $display("FAIL R5 tick edge actual=%0d expected=%0d", cyc, due);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int e;
    idle(4);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tick", {31'b0, tick}, 32'h0);
    rd(5'h00, 32'h0, "R1 cnt lo");
    rd(5'h04, 32'h0, "R1 cnt hi");
    rd(5'h08, 32'h0, "R1 ctrl");
    rd(5'h0C, 32'h0, "R1 status");
    rd(5'h10, 32'h0, "R1 cmp lo");
    rd(5'h18, 32'h0, "R1 step");

    // R3 counter words writable while stopped; R2 holds while stopped
    wr(5'h00, 32'hFFFF_FFFE);
    wr(5'h04, 32'h0000_0001);
    idle(3);
    rd(5'h00, 32'hFFFF_FFFE, "R2 hold lo");
    rd(5'h04, 32'h0000_0001, "R3 cnt hi write");

    // R2 carry: run for 5 edges
    wr(5'h08, 32'h1);
    idle(4);
    wr(5'h08, 32'h0);
    rd(5'h00, 32'h0000_0003, "R2 carry lo");
    rd(5'h04, 32'h0000_0002, "R2 carry hi");

    // R3 write ignored while running
    wr(5'h08, 32'h1);
    wr(5'h00, 32'h0000_1234);
    wr(5'h08, 32'h0);
    rd(5'h00, 32'h0000_0005, "R3 ignored lo");

    // R9 unused control bits read as zero
    wr(5'h08, 32'hFFFF_FFF0);
    rd(5'h08, 32'h0, "R9 ctrl upper zero");

    // R5/R7/R4/R8 compare on with value 0, interrupt disabled
    wr(5'h08, 32'h2);
    idle(2);
    rd(5'h0C, 32'h1, "R5 status set");
    chk("R8 irq gated", {31'b0, irq}, 32'h0);
    wr(5'h0C, 32'h0);
    rd(5'h0C, 32'h1, "R7 write0 no effect");
    wr(5'h0C, 32'h1);
    rd(5'h0C, 32'h0, "R7 w1c clears");
    wr(5'h10, 32'h0000_0055);
    rd(5'h10, 32'h0, "R4 cmp write ignored");
    wr(5'h08, 32'h0);

    // R5/R8 single match, no auto-increment
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd20);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'h0);
    wr(5'h08, 32'h7);
    e = last_edge;
    exp_q.push_back(e + 21);
    idle(30);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    rd(5'h0C, 32'h1, "R5 status after match");
    wr(5'h0C, 32'h1);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    chk("R5 one event", exp_q.size(), 32'h0);
    wr(5'h08, 32'h0);

    // R6 periodic ticks with step 8
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd10);
    wr(5'h18, 32'd8);
    wr(5'h08, 32'hF);
    e = last_edge;
    for (int k = 0; k < 4; k++) exp_q.push_back(e + 11 + 8 * k);
    idle(37);
    wr(5'h08, 32'h0);
    rd(5'h10, 32'd42, "R6 cmp advanced");
    rd(5'h14, 32'h0, "R6 cmp hi");
    idle(5);
    chk("R6 all ticks seen", exp_q.size(), 32'h0);
    rd(5'h18, 32'd8, "R9 step readback");

    finish_run();
  end
endmodule